// File: doc/BRIEF.md
# Home Snoop Directory Controller

This block is the coherence point for one slice of a shared physical address space. Every coherent request for a cache line in its slice passes through it. It keeps a small directory that records, for each tracked line, which request agents hold a copy and who is responsible for dirty data. A request reads the line's entry. The block then snoops only the agents that the sharer vector names, never all of them. It gathers their typed responses, folds them into the entry, and reports completion back to the requester.

Requests arrive on a valid/ready channel that carries a cache-line address, the requesting agent and a unique-versus-shared flag. Snoops leave on a valid/ready channel with a per-agent target mask and an invalidate flag. Responses return on a valid/ready channel, one per agent, each with a 3-bit code. The completion leaves on a valid/ready channel. The block works on one transaction at a time, so a second request stalls until the first has finished its completion handshake. The directory is direct-mapped. The low index bits of the line address pick the entry and the remaining bits form its tag. Each entry carries a tag, a sharer vector and a 2-bit dirty state: 0 means untracked, 1 means clean, 2 means dirty held by an agent. A transfer on any channel happens on a clock edge where valid and ready are both high. Once valid is raised it stays high, with its payload unchanged, until that edge.

Top module: `hsc_home`

## Requirements
- R1: The slice is the XOR-fold of all line-address bits into SLICE_B bits, where bit i feeds slice bit i mod SLICE_B. A request whose slice differs from SLICE_ID completes with cmp_foreign=1, cmp_wb=0 and cmp_dstate=0. It sends no snoop and leaves the directory unchanged.
- R2: req_ready is high only when no transaction is active. It drops on the edge that accepts a request and returns after the completion handshake.
- R3: On a tag hit, the snoop mask equals the sharer vector with the requester's bit cleared. When that mask is empty, no snoop is sent. A single holder receives a mask with exactly its own bit set.
- R4: snp_inval is 0 for a shared read that hits. It is 1 for a unique request and for an eviction.
- R5: Response code 7 means retry. The home waits until every agent in the current round has answered, then issues a new snoop whose mask holds only the agents that answered retry.
- R6: cmp_valid rises one cycle after the edge that accepts the last non-retry response. When no snoop is needed, it rises one cycle after the request is accepted.
- R7: After a shared read, the requester's sharer bit is set. Agents that answered with a dropping code (0 invalid, 2 unique-clean now invalid, 4 invalid with data, 6 passed dirty) lose their bit. Agents that answered 1 shared-clean, 3 shared-dirty or 5 shared-clean with data keep their bit.
- R8: After a unique request, the sharer vector holds only the requester.
- R9: The completed dirty state, reported on cmp_dstate, is 2 after a shared read hit in which some agent answered 3 (kept shared-dirty). In every other in-slice case it is 1.
- R10: cmp_wb is 1 exactly when some response in the transaction was code 6 (passed dirty), which hands the dirty line and its write-back to the home.
- R11: While snp_valid or cmp_valid is held without ready, the channel stays valid and its payload stays stable.
- R12: A request whose index maps to a tracked entry with a different tag evicts that line. Every recorded holder, including the requester, receives an invalidating snoop. The new tag is then installed with only the requester as holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready; high when idle |
| req_line | input | ADDR_W-LINE_B | Cache-line address |
| req_agent | input | $clog2(N_AG) | Requesting agent index |
| req_unique | input | 1 | 1 = unique request, 0 = shared read |
| snp_valid | output | 1 | Snoop valid |
| snp_ready | input | 1 | Snoop accepted by the network |
| snp_mask | output | N_AG | One bit per targeted agent |
| snp_inval | output | 1 | 1 = invalidating snoop, 0 = sharing snoop |
| rsp_valid | input | 1 | Snoop response valid |
| rsp_ready | output | 1 | High while responses are awaited |
| rsp_agent | input | $clog2(N_AG) | Responding agent |
| rsp_code | input | 3 | Response code (see R5, R7, R9, R10) |
| cmp_valid | output | 1 | Completion valid |
| cmp_ready | input | 1 | Completion accepted |
| cmp_agent | output | $clog2(N_AG) | Agent being completed |
| cmp_wb | output | 1 | Home owns passed-dirty data |
| cmp_foreign | output | 1 | Address outside this slice |
| cmp_dstate | output | 2 | Dirty state written to the entry |

## Verification
After the accepting request edge, either the snoop or the completion is visible in the very next cycle. Each response edge moves a round along by one agent. The completion, or a reissued retry snoop, appears in the cycle after the final response edge. The bench drives inputs and samples outputs on the falling edge. It checks that cmp_valid stays low right up to the final response and is high in the cycle after it. It also holds snoop and completion ready low for one cycle to confirm that the payload does not move. A bench-side directory model predicts every mask, dirty state and write-back flag. A later transaction to the same line exposes each directory update through the mask that transaction produces.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    DS_NONE  = 2'd0,
    DS_CLEAN = 2'd1,
    DS_DIRTY = 2'd2
  } hsc_dstate_e;

  typedef enum logic [2:0] {
    RSP_INV     = 3'd0,
    RSP_SC      = 3'd1,
    RSP_UC_INV  = 3'd2,
    RSP_SD      = 3'd3,
    RSP_D_INV   = 3'd4,
    RSP_D_SC    = 3'd5,
    RSP_D_PASS  = 3'd6,
    RSP_RETRY   = 3'd7
  } hsc_rsp_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE
  } hsc_state_e;
endpackage

// File: rtl/hsc_slice_hash.sv
module hsc_slice_hash #(
  parameter int LINE_W  = 10,
  parameter int SLICE_B = 1
) (
  input  logic [LINE_W-1:0]  line,
  output logic [SLICE_B-1:0] slice
);
  always_comb begin
    slice = '0;
    for (int i = 0; i < LINE_W; i++) begin
      slice[i % SLICE_B] = slice[i % SLICE_B] ^ line[i];
    end
  end
endmodule

// File: rtl/hsc_dir.sv
module hsc_dir
  import hsc_pkg::*;
#(
  parameter int N_AG  = 4,
  parameter int IDX_B = 2,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_B-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [N_AG-1:0]   rd_sh,
  output hsc_dstate_e       rd_ds,
  input  logic              wr_en,
  input  logic [IDX_B-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [N_AG-1:0]   wr_sh,
  input  hsc_dstate_e       wr_ds
);
  localparam int ENTRIES = 1 << IDX_B;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [N_AG-1:0]  sh_q  [ENTRIES];
  hsc_dstate_e      ds_q  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e] <= '0;
        sh_q[e]  <= '0;
        ds_q[e]  <= DS_NONE;
      end
    end else if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      sh_q[wr_idx]  <= wr_sh;
      ds_q[wr_idx]  <= wr_ds;
    end
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_sh  = sh_q[rd_idx];
  assign rd_ds  = ds_q[rd_idx];
endmodule

// File: rtl/hsc_rsp_decode.sv
module hsc_rsp_decode
  import hsc_pkg::*;
(
  input  logic [2:0] code,
  output logic       retry,
  output logic       drop,
  output logic       kept_dirty,
  output logic       passed_dirty
);
  hsc_rsp_e c;
  assign c = hsc_rsp_e'(code);

  always_comb begin
    retry        = (c == RSP_RETRY);
    kept_dirty   = (c == RSP_SD);
    passed_dirty = (c == RSP_D_PASS);
    unique case (c)
      RSP_INV, RSP_UC_INV, RSP_D_INV, RSP_D_PASS: drop = 1'b1;
      default:                                    drop = 1'b0;
    endcase
  end
endmodule

// File: rtl/hsc_home.sv
module hsc_home
  import hsc_pkg::*;
#(
  parameter int N_AG     = 4,
  parameter int ADDR_W   = 16,
  parameter int LINE_B   = 6,
  parameter int SLICE_B  = 1,
  parameter int SLICE_ID = 0,
  parameter int IDX_B    = 2,
  localparam int LINE_W  = ADDR_W - LINE_B,
  localparam int TAG_W   = LINE_W - IDX_B,
  localparam int AG_W    = $clog2(N_AG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [AG_W-1:0]   req_agent,
  input  logic              req_unique,
  output logic              snp_valid,
  input  logic              snp_ready,
  output logic [N_AG-1:0]   snp_mask,
  output logic              snp_inval,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [AG_W-1:0]   rsp_agent,
  input  logic [2:0]        rsp_code,
  output logic              cmp_valid,
  input  logic              cmp_ready,
  output logic [AG_W-1:0]   cmp_agent,
  output logic              cmp_wb,
  output logic              cmp_foreign,
  output logic [1:0]        cmp_dstate
);
  hsc_state_e st;

  logic [IDX_B-1:0] line_idx;
  logic [TAG_W-1:0] line_tag;
  logic [SLICE_B-1:0] slice_of;
  logic in_slice;
  assign line_idx = req_line[IDX_B-1:0];
  assign line_tag = req_line[LINE_W-1:IDX_B];

  hsc_slice_hash #(.LINE_W(LINE_W), .SLICE_B(SLICE_B)) u_hash (
    .line(req_line), .slice(slice_of)
  );
  assign in_slice = (slice_of == SLICE_B'(SLICE_ID));

  // registered transaction context
  logic [AG_W-1:0]  r_agent;
  logic [IDX_B-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic [N_AG-1:0]  r_sh, send_m, pend_m, again_m, drop_m;
  logic r_unique, r_foreign, r_hit, r_evict, sd_seen, pd_seen;

  // directory
  logic [TAG_W-1:0] rd_tag;
  logic [N_AG-1:0]  rd_sh, new_sh;
  hsc_dstate_e      rd_ds, new_ds;
  logic             wr_en;

  hsc_dir #(.N_AG(N_AG), .IDX_B(IDX_B), .TAG_W(TAG_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(line_idx), .rd_tag(rd_tag), .rd_sh(rd_sh), .rd_ds(rd_ds),
    .wr_en(wr_en), .wr_idx(r_idx), .wr_tag(r_tag), .wr_sh(new_sh), .wr_ds(new_ds)
  );

  // response decode
  logic d_retry, d_drop, d_kept_dirty, d_passed;
  hsc_rsp_decode u_dec (
    .code(rsp_code), .retry(d_retry), .drop(d_drop),
    .kept_dirty(d_kept_dirty), .passed_dirty(d_passed)
  );

  // lookup of the incoming request
  logic [N_AG-1:0] req_bit, own_bit, rsp_bit, targets, pend_n, again_n;
  logic hit, evict;
  always_comb begin
    req_bit = '0;  req_bit[req_agent] = 1'b1;
    own_bit = '0;  own_bit[r_agent]   = 1'b1;
    rsp_bit = '0;  rsp_bit[rsp_agent] = 1'b1;
    hit   = (rd_ds != DS_NONE) && (rd_tag == line_tag);
    evict = (rd_ds != DS_NONE) && !hit;
    if (!in_slice)  targets = '0;
    else if (hit)   targets = rd_sh & ~req_bit;
    else if (evict) targets = rd_sh;
    else            targets = '0;
    pend_n  = pend_m & ~rsp_bit;
    again_n = d_retry ? (again_m | rsp_bit) : again_m;
  end

  // directory update at completion
  always_comb begin
    if (r_unique || r_evict || !r_hit) new_sh = own_bit;
    else                               new_sh = (r_sh & ~drop_m) | own_bit;
    if (!r_unique && r_hit && sd_seen) new_ds = DS_DIRTY;
    else                               new_ds = DS_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      r_agent <= '0; r_idx <= '0; r_tag <= '0; r_sh <= '0;
      send_m <= '0; pend_m <= '0; again_m <= '0; drop_m <= '0;
      r_unique <= 1'b0; r_foreign <= 1'b0; r_hit <= 1'b0; r_evict <= 1'b0;
      sd_seen <= 1'b0; pd_seen <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          r_agent   <= req_agent;
          r_unique  <= req_unique;
          r_idx     <= line_idx;
          r_tag     <= line_tag;
          r_foreign <= !in_slice;
          r_hit     <= hit && in_slice;
          r_evict   <= evict && in_slice;
          r_sh      <= rd_sh;
          send_m    <= targets;
          again_m   <= '0;
          drop_m    <= '0;
          sd_seen   <= 1'b0;
          pd_seen   <= 1'b0;
          st <= (targets == '0) ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE: if (snp_ready) begin
          pend_m <= send_m;
          st     <= ST_WAIT;
        end
        ST_WAIT: if (rsp_valid) begin
          pend_m  <= pend_n;
          again_m <= again_n;
          if (!d_retry) begin
            if (d_drop) drop_m <= drop_m | rsp_bit;
            sd_seen <= sd_seen | d_kept_dirty;
            pd_seen <= pd_seen | d_passed;
          end
          if (pend_n == '0) begin
            if (again_n != '0) begin
              send_m  <= again_n;
              again_m <= '0;
              st      <= ST_ISSUE;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_DONE: if (cmp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign snp_valid   = (st == ST_ISSUE);
  assign snp_mask    = send_m;
  assign snp_inval   = r_unique || r_evict;
  assign rsp_ready   = (st == ST_WAIT);
  assign cmp_valid   = (st == ST_DONE);
  assign cmp_agent   = r_agent;
  assign cmp_wb      = pd_seen;
  assign cmp_foreign = r_foreign;
  assign cmp_dstate  = r_foreign ? DS_NONE : new_ds;
  assign wr_en       = cmp_valid && cmp_ready && !r_foreign;
endmodule

// File: rtl/hsc_home_chk.sv
module hsc_home_chk #(
  parameter int N_AG = 4,
  localparam int AG_W = $clog2(N_AG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            snp_valid,
  input logic            snp_ready,
  input logic [N_AG-1:0] snp_mask,
  input logic            snp_inval,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            cmp_valid,
  input logic            cmp_ready,
  input logic [AG_W-1:0] cmp_agent,
  input logic            cmp_wb,
  input logic            cmp_foreign,
  input logic [1:0]      cmp_dstate
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !snp_valid && !cmp_valid && !rsp_ready);

  p_snoop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> snp_mask != '0);

  p_snoop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_ready |=> snp_valid && $stable(snp_mask) && $stable(snp_inval));

  p_cmp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_ready |=> cmp_valid && $stable({cmp_agent, cmp_wb, cmp_foreign, cmp_dstate}));

  p_cmp_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_valid) |-> $past(req_valid && req_ready) || $past(rsp_valid && rsp_ready));

  p_foreign_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_foreign |-> !cmp_wb && cmp_dstate == 2'd0);
endmodule

bind hsc_home hsc_home_chk #(.N_AG(N_AG)) i_chk (.*);

// File: tb/test_hsc_home.sv
module test_hsc_home;
  localparam int CLK_PERIOD = 10;
  localparam int N_AG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_unique = 0, snp_ready = 0, rsp_valid = 0, cmp_ready = 0;
  logic [9:0] req_line = '0;
  logic [1:0] req_agent = '0, rsp_agent = '0;
  logic [2:0] rsp_code = '0;
  logic req_ready, snp_valid, snp_inval, rsp_ready, cmp_valid, cmp_wb, cmp_foreign;
  logic [3:0] snp_mask;
  logic [1:0] cmp_agent, cmp_dstate;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench-side directory model
  logic [1:0] m_ds [4];
  logic [7:0] m_tag [4];
  logic [3:0] m_sh [4];
  int code_of [4];
  bit retry_of [4];

  hsc_home #(.N_AG(N_AG), .ADDR_W(16), .LINE_B(6), .SLICE_B(1), .SLICE_ID(0), .IDX_B(2)) i_hsc_home (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .req_agent(req_agent), .req_unique(req_unique),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_mask(snp_mask), .snp_inval(snp_inval),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_agent(rsp_agent), .rsp_code(rsp_code),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_agent(cmp_agent),
    .cmp_wb(cmp_wb), .cmp_foreign(cmp_foreign), .cmp_dstate(cmp_dstate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mk_line(input logic [7:0] tag, input logic [1:0] idx, input bit foreign);
    logic [9:0] l;
    l = {tag, idx};
    if ((^l) != foreign) l[9] = ~l[9];
    return l;
  endfunction

  function automatic bit is_drop(input int c);
    return c == 0 || c == 2 || c == 4 || c == 6;
  endfunction

  task automatic run_txn(input logic [9:0] line, input int ag, input bit uq);
    bit foreign, hit, evict, inval, wbx, sdx;
    logic [1:0] idx;
    logic [7:0] tag;
    logic [3:0] tgt, round, nxt, rt, dropx, rbit;
    int exp_ds;
    foreign = ^line;
    idx = line[1:0];
    tag = line[9:2];
    hit   = !foreign && m_ds[idx] != 0 && m_tag[idx] == tag;
    evict = !foreign && m_ds[idx] != 0 && !hit;
    tgt   = hit ? (m_sh[idx] & ~(4'b1 << ag)) : (evict ? m_sh[idx] : 4'b0);
    inval = uq || evict;
    rbit  = 4'b1 << ag;
    wbx = 0; sdx = 0; dropx = 0;
    for (int a = 0; a < 4; a++) if (tgt[a]) begin
      if (code_of[a] == 6) wbx = 1;
      if (code_of[a] == 3) sdx = 1;
      if (is_drop(code_of[a])) dropx[a] = 1;
    end
    rt = 0;
    for (int a = 0; a < 4; a++) if (retry_of[a]) rt[a] = 1;
    rt = rt & tgt;

    req_valid = 1; req_line = line; req_agent = 2'(ag); req_unique = uq;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R2 ready low while busy", req_ready, 0);

    if (tgt == 0) begin
      check(snp_valid == 0, "R3 no snoop without holders", snp_valid, 0);
    end else begin
      round = tgt;
      forever begin
        check(snp_valid == 1 && snp_mask == round, "R3/R5 snoop mask", snp_mask, round);
        check(snp_inval == inval, "R4 snoop kind", snp_inval, inval);
        @(negedge clk);
        check(snp_valid == 1 && snp_mask == round, "R11 snoop held", snp_mask, round);
        snp_ready = 1;
        @(negedge clk);
        snp_ready = 0;
        nxt = 0;
        for (int a = 0; a < 4; a++) if (round[a]) begin
          check(cmp_valid == 0, "R6 no early completion", cmp_valid, 0);
          rsp_valid = 1; rsp_agent = 2'(a);
          if (rt[a]) begin rsp_code = 3'd7; rt[a] = 0; nxt[a] = 1; end
          else rsp_code = 3'(code_of[a]);
          @(negedge clk);
          rsp_valid = 0;
        end
        if (nxt == 0) break;
        round = nxt;
      end
    end
    exp_ds = foreign ? 0 : ((!uq && hit && sdx) ? 2 : 1);
    check(cmp_valid == 1, "R6 completion due", cmp_valid, 1);
    check(cmp_agent == 2'(ag), "R6 completion agent", cmp_agent, ag);
    check(cmp_foreign == foreign, "R1 foreign flag", cmp_foreign, foreign);
    check(cmp_wb == wbx, "R10 passed-dirty write-back", cmp_wb, wbx);
    check(cmp_dstate == 2'(exp_ds), "R9 dirty state", cmp_dstate, exp_ds);
    @(negedge clk);
    check(cmp_valid == 1 && cmp_dstate == 2'(exp_ds), "R11 completion held", cmp_valid, 1);
    check(req_ready == 0, "R2 stall until completion taken", req_ready, 0);
    cmp_ready = 1;
    @(negedge clk);
    cmp_ready = 0;
    check(req_ready == 1 && cmp_valid == 0, "R2 ready after completion", req_ready, 1);

    if (!foreign) begin
      if (uq || evict || !hit) m_sh[idx] = rbit;            // R8 R12
      else m_sh[idx] = (m_sh[idx] & ~dropx) | rbit;         // R7
      m_tag[idx] = tag;
      m_ds[idx] = 2'(exp_ds);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 4; e++) begin m_ds[e] = 0; m_tag[e] = 0; m_sh[e] = 0; end
    for (int a = 0; a < 4; a++) begin code_of[a] = 1; retry_of[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R2 reset ready", req_ready, 1);
    check(snp_valid == 0 && cmp_valid == 0 && rsp_ready == 0, "R2 reset quiet", snp_valid, 0);

    // shared reads by every agent on every entry: sharer vectors grow
    for (int i = 0; i < 4; i++)
      for (int a = 0; a < 4; a++)
        run_txn(mk_line(8'(i*37+5), 2'(i), 0), a, 0);
    // re-read by a holder: snoops the others only
    run_txn(mk_line(8'(5), 2'd0, 0), 2, 0);

    // unique with passed dirty, a retry and mixed codes
    code_of[0] = 6; code_of[2] = 1; code_of[3] = 0; retry_of[3] = 1;
    run_txn(mk_line(8'(5), 2'd0, 0), 1, 1);
    retry_of[3] = 0;
    // single holder gets a lone shared snoop, answers shared-dirty
    code_of[1] = 3;
    run_txn(mk_line(8'(5), 2'd0, 0), 3, 0);
    // read after dirty: holder drops unique-clean, other keeps
    code_of[1] = 2; code_of[3] = 1;
    run_txn(mk_line(8'(5), 2'd0, 0), 0, 0);
    run_txn(mk_line(8'(5), 2'd0, 0), 0, 1);

    // eviction of entry 1 (all four hold it) by a new tag
    code_of[0] = 4; code_of[1] = 5; code_of[2] = 6; code_of[3] = 7;
    retry_of[3] = 1; code_of[3] = 1;
    run_txn(mk_line(8'(142), 2'd1, 0), 2, 0);
    retry_of[3] = 0;

    // foreign address on entry 2, then confirm entry 2 untouched
    run_txn(mk_line(8'(200), 2'd2, 1), 1, 1);
    for (int c = 0; c < 7; c++) begin
      for (int a = 0; a < 4; a++) code_of[a] = c;
      run_txn(mk_line(8'(79), 2'd2, 0), c % 4, 0);
      run_txn(mk_line(8'(79), 2'd2, 0), (c + 1) % 4, 0);
    end
    // all response codes on entry 3 under unique requests
    for (int c = 0; c < 7; c++) begin
      for (int a = 0; a < 4; a++) code_of[a] = c;
      for (int a = 0; a < 4; a++) run_txn(mk_line(8'(116), 2'd3, 0), a, 0);
      run_txn(mk_line(8'(116), 2'd3, 0), c % 4, 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule